// File: doc/BRIEF.md
# PCI Interrupt Steering Router

This block collects the four level-sensitive INTx pins of every device slot on a PCI bus and folds them onto eight shared PIRQ lines, using one routing word per slot. Each PIRQ then appears in two interrupt views at the same time. In the legacy view, a per-PIRQ route byte names one of sixteen PIC inputs, or turns the PIRQ off for that view. In the APIC view, PIRQ n always drives GSI 16+n, and the route byte has no effect there. A power-management SCI level is OR-merged onto one line chosen by a small select register.

The result is a registered 24-line GSI vector. Lines 0..15 feed the legacy controller and lines 16..23 feed the APIC. Software programs the routing through a flat register port with a write strobe, an address and write data. Read data is combinational from the stored registers. Slot 30 sits behind a bridge and is hard-wired, so it cannot be reprogrammed.

The SCI path is a two-state machine. In `SCI_IDLE` the SCI drives no line. The `RAISE` transition moves it to `SCI_ASSERTED` when `sci_in` is high. The `RELEASE` transition returns it to `SCI_IDLE` when `sci_in` is low. While it stays in `SCI_ASSERTED`, the `HOLD` self-loop keeps the current line. The `RETARGET` self-loop moves the driven line whenever the select register changes: the old line drops and the new one rises on the same edge.

Top module: `irq_steer_router`

## Requirements
- R1: Slot s has a routing word at address s. INTx pin i (INTA=0..INTD=3) uses the field at bits [4i+3:4i]. Only the low 3 bits of a field select a PIRQ (0=A..7=H), and bit 4i+3 is ignored.
- R2: Slot 30 always reads 16'h7654 and ignores writes, so its INTA..INTD always reach PIRQ 4..7.
- R3: After reset, slot s pin i routes to PIRQ ((s+i) mod 4)+4. Every route byte reads 8'h80 (disabled), the SCI select reads 0, and all 24 GSI outputs are low.
- R4: PIRQ n has its route byte at address 32+n. Bit 7 set means disabled, and bits [4:0] hold the IRQ number. PIC line L is the OR of every active PIRQ whose byte is enabled with IRQ number L, so several PIRQs can share a line.
- R5: A route byte that is enabled but holds an IRQ number of 16 or above gives no PIC contribution. A disabled PIRQ reaches no PIC line either.
- R6: GSI 16+n follows PIRQ n whatever its route byte holds.
- R7: The SCI select register is at address 40, bits [2:0]. Codes 0..4 select GSI 9, 10, 11, 20 and 21, and codes 5..7 select no line. An asserted SCI is ORed onto the selected line.
- R8: While SCI is asserted, changing the select register drops the old line and raises the new one on the same edge. A PIRQ that shares the old line keeps it high, and rewriting the same SCI level changes nothing.
- R9: An input change or register write captured on a rising edge shows at `gsi_out` on the next rising edge, and not before.
- R10: Reads return the stored value, with route bytes and the select register zero-extended. Addresses 41 and above read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| intx_in | input | NUM_SLOTS*4 | INTx levels; bit 4s+i is slot s pin i |
| sci_in | input | 1 | SCI level |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr |
| gsi_out | output | 24 | GSI levels: 0..15 PIC, 16..23 APIC |

## Verification
Two functions can land on the same line in the same cycle. The SCI merge and a PIRQ steered through its route byte can both target one PIC line, and the SCI can also target an APIC line that a PIRQ drives one-to-one. The bench provokes this by routing a PIRQ to IRQ 10 while the SCI also points there, then moving the SCI to IRQ 11 with both sources held high. It also points the SCI at GSI 20 and GSI 21, where PIRQ E and F land. A scoreboard model built from the requirements judges each case: the shared line must stay high until its last source drops, and the moved SCI must never show on two lines at once.

// File: rtl/irq_steer_pkg.sv
package irq_steer_pkg;
    localparam int PINS      = 4;
    localparam int PIRQS     = 8;
    localparam int PIRQ_W    = 3;
    localparam int FIELD_W   = 4;
    localparam int WORD_W    = PINS * FIELD_W;
    localparam int ROUTE_W   = 8;
    localparam int IRQ_W     = 5;
    localparam int DIS_BIT   = 7;
    localparam int PIC_LINES = 16;
    localparam int APIC_BASE = PIC_LINES;
    localparam int GSI_LINES = APIC_BASE + PIRQS;
    localparam int GSI_W     = 5;
    localparam int SEL_W     = 3;
    localparam int DATA_W    = 16;
    localparam logic [ROUTE_W-1:0] ROUTE_RESET = 8'h80;

    typedef enum logic [0:0] {
        SCI_IDLE     = 1'b0,
        SCI_ASSERTED = 1'b1
    } sci_state_e;

    typedef struct packed {
        logic             valid;
        logic [GSI_W-1:0] line;
    } sci_target_t;

    // Power-up routing word: pin i of slot s lands on PIRQ ((s+i) mod 4) + 4.
    function automatic logic [WORD_W-1:0] reset_word(input int slot);
        logic [WORD_W-1:0] w;
        w = '0;
        for (int i = 0; i < PINS; i++) begin
            w[i*FIELD_W +: FIELD_W] = FIELD_W'(((slot + i) % 4) + 4);
        end
        return w;
    endfunction

    // Hard-wired word of the bridge slot: INTA..INTD to PIRQ E..H.
    function automatic logic [WORD_W-1:0] fixed_word();
        logic [WORD_W-1:0] w;
        w = '0;
        for (int i = 0; i < PINS; i++) begin
            w[i*FIELD_W +: FIELD_W] = FIELD_W'(i + 4);
        end
        return w;
    endfunction

    function automatic sci_target_t decode_sci(input logic [SEL_W-1:0] code);
        sci_target_t t;
        case (code)
            3'd0:    t = '{valid: 1'b1, line: 5'd9};
            3'd1:    t = '{valid: 1'b1, line: 5'd10};
            3'd2:    t = '{valid: 1'b1, line: 5'd11};
            3'd3:    t = '{valid: 1'b1, line: 5'd20};
            3'd4:    t = '{valid: 1'b1, line: 5'd21};
            default: t = '{valid: 1'b0, line: 5'd0};
        endcase
        return t;
    endfunction
endpackage

// File: rtl/irq_intx_merge.sv
module irq_intx_merge
    import irq_steer_pkg::*;
#(
    parameter int NUM_SLOTS = 32
) (
    input  logic [NUM_SLOTS*PINS-1:0]   intx,
    input  logic [NUM_SLOTS*WORD_W-1:0] words,
    output logic [PIRQS-1:0]            pirq_lvl
);
    localparam int TOTAL_PINS = NUM_SLOTS * PINS;

    for (genvar p = 0; p < PIRQS; p++) begin : g_pirq
        logic [TOTAL_PINS-1:0] hit;
        for (genvar k = 0; k < TOTAL_PINS; k++) begin : g_pin
            // Field k sits at bit k*FIELD_W; only its low PIRQ_W bits count.
            assign hit[k] = intx[k] &&
                            (words[k*FIELD_W +: PIRQ_W] == PIRQ_W'(p));
        end
        assign pirq_lvl[p] = |hit;
    end
endmodule

// File: rtl/irq_pic_steer.sv
module irq_pic_steer
    import irq_steer_pkg::*;
(
    input  logic [PIRQS-1:0]         pirq_lvl,
    input  logic [PIRQS*ROUTE_W-1:0] routes,
    input  logic [GSI_LINES-1:0]     sci_vec,
    output logic [GSI_LINES-1:0]     gsi_next
);
    // Shared legacy view: gated by each PIRQ's disable bit.
    for (genvar l = 0; l < PIC_LINES; l++) begin : g_pic
        logic [PIRQS-1:0] src;
        for (genvar p = 0; p < PIRQS; p++) begin : g_src
            assign src[p] = pirq_lvl[p] &&
                            !routes[p*ROUTE_W + DIS_BIT] &&
                            (routes[p*ROUTE_W +: IRQ_W] == IRQ_W'(l));
        end
        assign gsi_next[l] = (|src) | sci_vec[l];
    end

    // Dedicated view: one line per PIRQ, never gated.
    for (genvar n = 0; n < PIRQS; n++) begin : g_apic
        assign gsi_next[APIC_BASE+n] = pirq_lvl[n] | sci_vec[APIC_BASE+n];
    end
endmodule

// File: rtl/irq_sci_tracker.sv
module irq_sci_tracker
    import irq_steer_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sci_lvl,
    input  logic [SEL_W-1:0]     sel_code,
    output sci_state_e           state,
    output logic [GSI_LINES-1:0] sci_vec
);
    sci_state_e  state_q;
    sci_state_e  state_d;
    sci_target_t tgt;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SCI_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SCI_IDLE:     if (sci_lvl)  state_d = SCI_ASSERTED; // RAISE
            SCI_ASSERTED: if (!sci_lvl) state_d = SCI_IDLE;     // RELEASE
            default:      state_d = SCI_IDLE;
        endcase
    end

    // Target is decoded live, so RETARGET swaps lines on one edge.
    always_comb begin
        tgt     = decode_sci(sel_code);
        sci_vec = '0;
        unique case (state_q)
            SCI_IDLE:     sci_vec = '0;
            SCI_ASSERTED: if (tgt.valid) sci_vec[tgt.line] = 1'b1;
            default:      sci_vec = '0;
        endcase
    end

    assign state = state_q;
endmodule

// File: rtl/irq_steer_router.sv
module irq_steer_router
    import irq_steer_pkg::*;
#(
    parameter int NUM_SLOTS  = 32,
    parameter int FIXED_SLOT = 30,
    parameter int ADDR_W     = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_SLOTS*PINS-1:0] intx_in,
    input  logic                      sci_in,
    input  logic                      reg_wr,
    input  logic [ADDR_W-1:0]         reg_addr,
    input  logic [DATA_W-1:0]         reg_wdata,
    output logic [DATA_W-1:0]         reg_rdata,
    output logic [GSI_LINES-1:0]      gsi_out
);
    localparam int ROUTE_BASE = NUM_SLOTS;
    localparam int ROUTE_END  = ROUTE_BASE + PIRQS;
    localparam int SEL_ADDR   = ROUTE_END;

    logic [NUM_SLOTS*WORD_W-1:0] words_q;
    logic [PIRQS*ROUTE_W-1:0]    routes_q;
    logic [SEL_W-1:0]            sel_q;
    logic [NUM_SLOTS*PINS-1:0]   intx_q;
    logic [PIRQS-1:0]            pirq_lvl;
    logic [GSI_LINES-1:0]        sci_vec;
    logic [GSI_LINES-1:0]        gsi_next;
    sci_state_e                  sci_state;
    int                          idx;

    assign idx = int'(reg_addr);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NUM_SLOTS; s++) begin
                words_q[s*WORD_W +: WORD_W] <= (s == FIXED_SLOT) ? fixed_word()
                                                                 : reset_word(s);
            end
        end else if (reg_wr && idx < NUM_SLOTS && idx != FIXED_SLOT) begin
            words_q[idx*WORD_W +: WORD_W] <= reg_wdata[WORD_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < PIRQS; p++) routes_q[p*ROUTE_W +: ROUTE_W] <= ROUTE_RESET;
        end else if (reg_wr && idx >= ROUTE_BASE && idx < ROUTE_END) begin
            routes_q[(idx-ROUTE_BASE)*ROUTE_W +: ROUTE_W] <= reg_wdata[ROUTE_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                          sel_q <= '0;
        else if (reg_wr && idx == SEL_ADDR) sel_q <= reg_wdata[SEL_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            intx_q  <= '0;
            gsi_out <= '0;
        end else begin
            intx_q  <= intx_in;
            gsi_out <= gsi_next;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (idx < NUM_SLOTS)
            reg_rdata = words_q[idx*WORD_W +: WORD_W];
        else if (idx < ROUTE_END)
            reg_rdata = DATA_W'(routes_q[(idx-ROUTE_BASE)*ROUTE_W +: ROUTE_W]);
        else if (idx == SEL_ADDR)
            reg_rdata = DATA_W'(sel_q);
    end

    irq_intx_merge #(.NUM_SLOTS(NUM_SLOTS)) u_merge (
        .intx     (intx_q),
        .words    (words_q),
        .pirq_lvl (pirq_lvl)
    );

    irq_sci_tracker u_sci (
        .clk      (clk),
        .rst_n    (rst_n),
        .sci_lvl  (sci_in),
        .sel_code (sel_q),
        .state    (sci_state),
        .sci_vec  (sci_vec)
    );

    irq_pic_steer u_steer (
        .pirq_lvl (pirq_lvl),
        .routes   (routes_q),
        .sci_vec  (sci_vec),
        .gsi_next (gsi_next)
    );
endmodule

// File: rtl/irq_steer_router_chk.sv
module irq_steer_router_chk
    import irq_steer_pkg::*;
#(
    parameter int NUM_SLOTS  = 32,
    parameter int FIXED_SLOT = 30
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [NUM_SLOTS*PINS-1:0] intx_q,
    input logic [PIRQS-1:0]          pirq_lvl,
    input logic [PIRQS*ROUTE_W-1:0]  routes_q,
    input logic [SEL_W-1:0]          sel_q,
    input sci_state_e                sci_state,
    input logic [GSI_LINES-1:0]      sci_vec,
    input logic [GSI_LINES-1:0]      gsi_out
);
    logic pic_live;
    always_comb begin
        pic_live = 1'b0;
        for (int p = 0; p < PIRQS; p++) begin
            if (!routes_q[p*ROUTE_W + DIS_BIT] && routes_q[p*ROUTE_W +: IRQ_W] < IRQ_W'(PIC_LINES))
                pic_live = 1'b1;
        end
    end

    for (genvar n = 0; n < PIRQS; n++) begin : g_apic_chk
        assert_apic_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
            pirq_lvl[n] |=> gsi_out[APIC_BASE+n]);
        assert_apic_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (!pirq_lvl[n] && !sci_vec[APIC_BASE+n]) |=> !gsi_out[APIC_BASE+n]);
    end

    if (FIXED_SLOT < NUM_SLOTS) begin : g_fixed_chk
        for (genvar i = 0; i < PINS; i++) begin : g_pin
            assert_fixed_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
                intx_q[FIXED_SLOT*PINS+i] |-> pirq_lvl[4+i]);
        end
    end

    assert_sci_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sci_vec));

    assert_sci_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sci_state == SCI_IDLE) |-> (sci_vec == '0));

    assert_sci_irq9_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sci_state == SCI_ASSERTED && sel_q == '0) |=> gsi_out[9]);

    assert_pic_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!pic_live && sci_vec[PIC_LINES-1:0] == '0) |=> (gsi_out[PIC_LINES-1:0] == '0));
endmodule

bind irq_steer_router irq_steer_router_chk #(
    .NUM_SLOTS  (NUM_SLOTS),
    .FIXED_SLOT (FIXED_SLOT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .intx_q    (intx_q),
    .pirq_lvl  (pirq_lvl),
    .routes_q  (routes_q),
    .sel_q     (sel_q),
    .sci_state (sci_state),
    .sci_vec   (sci_vec),
    .gsi_out   (gsi_out)
);

// File: tb/irq_steer_router_test.sv
`timescale 1ns/1ps
module irq_steer_router_test;
    localparam int NS = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NS*4-1:0] intx;
    logic          sci;
    logic          wr;
    logic [5:0]    addr;
    logic [15:0]   wdata;
    logic [15:0]   rdata;
    logic [23:0]   gsi;

    always #2.5 clk = ~clk;

    irq_steer_router uut (
        .clk(clk), .rst_n(rst_n), .intx_in(intx), .sci_in(sci),
        .reg_wr(wr), .reg_addr(addr), .reg_wdata(wdata),
        .reg_rdata(rdata), .gsi_out(gsi)
    );

    int total = 0;
    int bad   = 0;

    logic [15:0] m_word [NS];
    logic [7:0]  m_route [8];
    logic [2:0]  m_sel;

    logic [23:0] exp_q [$];
    string       tag_q [$];

    function automatic logic [23:0] model();
        logic [23:0] g;
        logic [7:0]  pirq;
        g = '0; pirq = '0;
        for (int s = 0; s < NS; s++)
            for (int i = 0; i < 4; i++)
                if (intx[s*4+i]) pirq[m_word[s][i*4 +: 3]] = 1'b1;
        for (int p = 0; p < 8; p++) begin
            if (pirq[p] && !m_route[p][7] && m_route[p][4:0] < 5'd16)
                g[m_route[p][3:0]] = 1'b1;
            if (pirq[p]) g[16+p] = 1'b1;
        end
        if (sci) begin
            case (m_sel)
                3'd0: g[9]  = 1'b1;
                3'd1: g[10] = 1'b1;
                3'd2: g[11] = 1'b1;
                3'd3: g[20] = 1'b1;
                3'd4: g[21] = 1'b1;
                default: ;
            endcase
        end
        return g;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: pops scoreboard items and compares away from the active edge.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [23:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, 32'(gsi), 32'(e));
        end
    end

    task automatic expect_gsi(input string tag);
        @(posedge clk);
        @(posedge clk);
        exp_q.push_back(model());
        tag_q.push_back(tag);
        @(negedge clk);
    endtask

    task automatic do_write(input int a, input logic [15:0] d);
        @(posedge clk); #1;
        wr = 1'b1; addr = 6'(a); wdata = d;
        @(posedge clk); #1;
        wr = 1'b0;
        if (a < NS && a != 30) m_word[a] = d;
        else if (a >= 32 && a < 40) m_route[a-32] = d[7:0];
        else if (a == 40) m_sel = d[2:0];
    endtask

    task automatic read_check(input int a, input logic [15:0] e, input string tag);
        @(posedge clk); #1;
        addr = 6'(a);
        #1;
        check(tag, 32'(rdata), 32'(e));
    endtask

    task automatic set_pin(input int s, input int i, input logic v);
        @(posedge clk); #1;
        intx[s*4+i] = v;
    endtask

    task automatic set_sci(input logic v);
        @(posedge clk); #1;
        sci = v;
    endtask

    initial begin
        #500000;
        bad++; total++;
        $display("FAIL watchdog R9 actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int s = 0; s < NS; s++)
            for (int i = 0; i < 4; i++) m_word[s][i*4 +: 4] = 4'(((s + i) % 4) + 4);
        m_word[30] = 16'h7654;
        for (int p = 0; p < 8; p++) m_route[p] = 8'h80;
        m_sel = '0;
        rst_n = 1'b0; intx = '0; sci = 1'b0; wr = 1'b0; addr = '0; wdata = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R3 outputs low after reset", 32'(gsi), 32'h0);
        read_check(0,  16'h7654, "R3 slot0 word");
        read_check(1,  16'h4765, "R3 slot1 word");
        read_check(32, 16'h0080, "R3 route byte disabled");
        read_check(40, 16'h0000, "R3 sci select");

        // R1/R3: slot1 INTA defaults to PIRQ F -> GSI 21 only
        set_pin(1, 0, 1'b1);
        expect_gsi("R1 default routing slot1 INTA");
        check("R3 default lands on GSI21", 32'(gsi), 32'h0020_0000);

        // R4: enable PIRQ F to IRQ 11
        do_write(37, 16'h000B);
        expect_gsi("R4 pirq F to irq11");
        // R4: PIRQ E shares IRQ 11
        do_write(36, 16'h000B);
        set_pin(1, 0, 1'b0);
        set_pin(0, 0, 1'b1);
        expect_gsi("R4 shared irq11 by pirq E");
        // R5: IRQ 18 enabled -> no PIC line
        do_write(36, 16'h0012);
        expect_gsi("R5 irq above 15");
        check("R5 pic lines quiet", 32'(gsi[15:0]), 32'h0);
        do_write(36, 16'h008B);
        expect_gsi("R5 disabled pirq R6 apic stays");

        // R2: fixed slot
        do_write(30, 16'h0000);
        read_check(30, 16'h7654, "R2 fixed word ignores write");
        set_pin(0, 0, 1'b0);
        set_pin(30, 1, 1'b1);
        expect_gsi("R2 slot30 INTB to pirq F");
        set_pin(30, 1, 1'b0);

        // R1: reprogram slot 2, field top bit ignored
        do_write(2, 16'h0A10);
        read_check(2, 16'h0A10, "R10 slot word readback");
        set_pin(2, 2, 1'b1);
        expect_gsi("R1 INTC field 0xA selects pirq C");
        set_pin(2, 2, 1'b0);
        set_pin(2, 1, 1'b1);
        expect_gsi("R1 INTB field selects pirq B");
        set_pin(2, 1, 1'b0);

        // R7: SCI codes
        set_sci(1'b1);
        expect_gsi("R7 sci code0 gsi9");
        do_write(40, 16'h0003);
        expect_gsi("R7 sci code3 gsi20");
        do_write(40, 16'h0004);
        expect_gsi("R7 sci code4 gsi21");
        do_write(40, 16'h0006);
        expect_gsi("R7 sci code6 no line");
        check("R7 no line driven", 32'(gsi), 32'h0);

        // R8: SCI and PIRQ D share IRQ 10, then SCI moves
        do_write(40, 16'h0001);
        expect_gsi("R8 sci on irq10");
        do_write(35, 16'h000A);
        do_write(3, 16'h0003);
        set_pin(3, 0, 1'b1);
        expect_gsi("R8 pirq D and sci share irq10");
        do_write(40, 16'h0002);
        expect_gsi("R8 retarget keeps pirq on irq10");
        set_pin(3, 0, 1'b0);
        expect_gsi("R8 sci alone on irq11");
        do_write(40, 16'h0001);
        expect_gsi("R8 move releases old line");
        check("R8 only irq10 high", 32'(gsi), 32'h0000_0400);
        set_sci(1'b1);
        expect_gsi("R8 repeated level no change");

        // R9: latency
        set_pin(1, 0, 1'b1);
        @(negedge clk);
        check("R9 before capture edge", 32'(gsi[21]), 32'h0);
        @(negedge clk);
        check("R9 after capture edge", 32'(gsi[21]), 32'h0);
        @(negedge clk);
        check("R9 one edge after capture", 32'(gsi[21]), 32'h1);

        // R10: reads and unmapped space
        read_check(50, 16'h0000, "R10 unmapped read");
        do_write(50, 16'hFFFF);
        read_check(32, 16'h0080, "R10 unmapped write ignored");
        do_write(33, 16'h006B);
        read_check(33, 16'h006B, "R10 route readback");
        read_check(40, 16'h0001, "R10 select readback");
        expect_gsi("R10 state after unmapped write");

        repeat (4) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule